// File: doc/BRIEF.md
# UART Transmitter with Per-Bit Width Trim

This block turns one byte at a time into an asynchronous serial frame on a single output line. A frame is a low start bit, five to eight data bits sent least significant first, an optional parity bit and one or two high stop bits. The line rests high between frames. The time base comes from a divisor. Each bit is built from sixteen sub-ticks, and each sub-tick lasts divisor + 1 clocks.

Every position in the frame has its own 2-bit trim code. The code can stretch that bit to seventeen sub-ticks or shrink it to fifteen. Spreading a few trimmed bits across a frame lets software set the average bitrate more finely than the divisor alone allows. The byte, the format word, the trim vector and the divisor are all captured when a byte is accepted. A break request holds the line low once the current frame has ended.

Top module: `uart_trim_tx`

## Requirements
- R1: After reset, and whenever no frame or break is active, `txd` is 1. After reset, `tx_empty` is 1 and, with `brk_req` low, `tx_ready` is 1.
- R2: `tx_ready` is 1 only when no frame is being sent and `brk_req` is 0. A byte is accepted on a rising edge where `tx_valid` and `tx_ready` are both 1. From that edge `txd` drives the start bit (0). After the frame ends, at least one idle cycle passes before the next byte is accepted.
- R3: With trim code 0 or 2, a bit lasts exactly 16 × (divisor + 1) clocks. `txd` changes only at bit boundaries.
- R4: Position p of the frame is counted in sending order, with the start bit as position 0. Its trim code is `trim_vec[2p+1:2p]`. Code 1 makes that bit 17 × (divisor + 1) clocks long and code 3 makes it 15 × (divisor + 1) clocks long.
- R5: `fmt_word[1:0]` selects the number of data bits: 0, 1, 2 and 3 give 5, 6, 7 and 8 bits. Data bits are sent starting from bit 0 of the byte.
- R6: `fmt_word[2]` selects the stop bits: 0 gives one stop bit and 1 gives two. Stop bits are 1.
- R7: `fmt_word[5:3]` sets parity, which follows the last data bit. The codes are:
  - 4: odd (the data bits and the parity bit together hold an odd number of ones).
  - 5: even.
  - 6: always 1.
  - 7: always 0.
  - 0 to 3: no parity bit.
- R8: While `brk_req` is 1, `txd` is held at 0. A break starts at once if the line is idle, or right after the last stop bit if a frame is in progress. No byte is accepted during a break. One clock after `brk_req` falls, `txd` returns to 1.
- R9: `tx_empty` is 1 exactly when no frame is in progress and `tx_valid` is 0.
- R10: Changing `tx_data`, `fmt_word`, `trim_vec` or `divisor` during a frame has no effect on that frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tx_data | input | 8 | Byte to send |
| tx_valid | input | 1 | A byte is offered |
| tx_ready | output | 1 | The byte is taken on this edge when `tx_valid` is 1 |
| divisor | input | DIV_W (12) | Sub-tick length minus one, in clocks |
| fmt_word | input | 6 | [1:0] data length, [2] stop bits, [5:3] parity |
| brk_req | input | 1 | Hold the line low after the current frame |
| trim_vec | input | 24 | One 2-bit trim code per frame position |
| txd | output | 1 | Serial line |
| tx_empty | output | 1 | No frame in progress and no byte offered |

## Verification
The bench checks the line clock by clock against a waveform it builds itself from the format word, the trim codes and the divisor. Trimmed bits are placed between bits of opposite level, so a design that applies a code to the wrong position, or confuses code 1 with code 3, moves a boundary and is caught on the exact cycle. The table covers every data length, both stop settings and every parity mode, including a parity code with the top bit clear that must send no parity bit. A design that counts parity over unsent data bits, or inverts odd and even, shows a wrong level at the parity position. Directed cases cover the following:
- Changing all settings in the middle of a frame, which catches a design that does not capture them at acceptance.
- A break requested mid-frame, which must not cut the stop bits short.
- A break started from idle while a byte is offered, which must neither accept the byte nor raise `tx_empty`.

// File: rtl/uart_trim_pkg.sv
package uart_trim_pkg;

  localparam int MAX_POS  = 12;
  localparam int POS_W    = 4;
  localparam int SUB_W    = 5;
  localparam int TRIM_W   = 2 * MAX_POS;

  typedef enum logic [1:0] {ST_IDLE, ST_SEND, ST_BRK} tx_state_t;

  typedef struct packed {
    logic [7:0]        data;
    logic [5:0]        fmt;
    logic [TRIM_W-1:0] trim;
  } frame_cfg_t;

  // number of data bits for a length code
  function automatic logic [POS_W-1:0] data_bits(input logic [1:0] code);
    return 4'd5 + {2'b00, code};
  endfunction

  function automatic logic parity_on(input logic [5:0] fmt);
    return fmt[5];
  endfunction

  // total positions: start + data + parity + stop(s)
  function automatic logic [POS_W-1:0] frame_len(input logic [5:0] fmt);
    return 4'd1 + data_bits(fmt[1:0]) + {3'b000, parity_on(fmt)}
         + (fmt[2] ? 4'd2 : 4'd1);
  endfunction

  function automatic logic parity_value(input logic [2:0] pm,
                                        input logic [7:0] d,
                                        input logic [1:0] len);
    logic [7:0] mask;
    logic [7:0] used;
    mask = 8'hFF >> (3'd3 - {1'b0, len});
    used = d & mask;
    case (pm)
      3'd4:    return ~(^used);
      3'd5:    return ^used;
      3'd6:    return 1'b1;
      3'd7:    return 1'b0;
      default: return 1'b1;
    endcase
  endfunction

  // line level for a frame position
  function automatic logic frame_bit(input logic [POS_W-1:0] pos,
                                     input logic [7:0]       d,
                                     input logic [5:0]       fmt);
    logic [POS_W-1:0] nd;
    nd = data_bits(fmt[1:0]);
    if (pos == '0) return 1'b0;
    if (pos <= nd) return d[3'(pos - 4'd1)];
    if (parity_on(fmt) && (pos == nd + 4'd1))
      return parity_value(fmt[5:3], d, fmt[1:0]);
    return 1'b1;
  endfunction

  // sub-ticks in one bit for a trim code
  function automatic logic [SUB_W-1:0] trim_len(input logic [1:0] code);
    case (code)
      2'd1:    return 5'd17;
      2'd3:    return 5'd15;
      default: return 5'd16;
    endcase
  endfunction

endpackage

// File: rtl/tx_subtick_gen.sv
module tx_subtick_gen #(
  parameter int DIV_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             sub_tick
);
  logic [DIV_W-1:0] cnt_q;

  assign sub_tick = run && (cnt_q == div);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt_q <= '0;
    else if (!run)     cnt_q <= '0;
    else if (sub_tick) cnt_q <= '0;
    else               cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/tx_bit_timer.sv
module tx_bit_timer
  import uart_trim_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             sub_tick,
  input  logic [SUB_W-1:0] target,
  output logic             bit_done
);
  logic [SUB_W-1:0] sub_q;

  assign bit_done = sub_tick && (sub_q == target - 5'd1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        sub_q <= '0;
    else if (!run)     sub_q <= '0;
    else if (bit_done) sub_q <= '0;
    else if (sub_tick) sub_q <= sub_q + 5'd1;
  end
endmodule

// File: rtl/tx_frame_seq.sv
module tx_frame_seq
  import uart_trim_pkg::*;
#(
  parameter int DIV_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [7:0]        tx_data,
  input  logic              tx_valid,
  input  logic [DIV_W-1:0]  divisor,
  input  logic [5:0]        fmt_word,
  input  logic              brk_req,
  input  logic [TRIM_W-1:0] trim_vec,
  input  logic              bit_done,
  output logic              tx_ready,
  output logic              frame_busy,
  output logic              brk_hold,
  output logic              last_bit,
  output logic [DIV_W-1:0]  div_q,
  output logic [SUB_W-1:0]  bit_target,
  output logic              txd
);
  tx_state_t        state_q;
  frame_cfg_t       cfg_q;
  logic [POS_W-1:0] pos_q;
  logic [POS_W-1:0] n_pos;
  logic [1:0]       code_at [MAX_POS];
  logic             accept;
  logic             txd_q;

  genvar g;
  generate
    for (g = 0; g < MAX_POS; g++) begin : g_trim
      assign code_at[g] = cfg_q.trim[2*g +: 2];
    end
  endgenerate

  assign n_pos      = frame_len(cfg_q.fmt);
  assign frame_busy = (state_q == ST_SEND);
  assign brk_hold   = (state_q == ST_BRK);
  assign last_bit   = frame_busy && (pos_q == n_pos - 4'd1);
  assign tx_ready   = (state_q == ST_IDLE) && !brk_req;
  assign accept     = tx_valid && tx_ready;
  assign bit_target = trim_len(code_at[pos_q]);
  assign txd        = txd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cfg_q   <= '0;
      div_q   <= '0;
      pos_q   <= '0;
      txd_q   <= 1'b1;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (accept) begin
            cfg_q   <= '{data: tx_data, fmt: fmt_word, trim: trim_vec};
            div_q   <= divisor;
            pos_q   <= '0;
            txd_q   <= 1'b0;
            state_q <= ST_SEND;
          end else if (brk_req) begin
            txd_q   <= 1'b0;
            state_q <= ST_BRK;
          end
        end
        ST_SEND: begin
          if (bit_done) begin
            if (last_bit) begin
              txd_q   <= !brk_req ? 1'b1 : 1'b0;
              state_q <= brk_req ? ST_BRK : ST_IDLE;
            end else begin
              pos_q <= pos_q + 4'd1;
              txd_q <= frame_bit(pos_q + 4'd1, cfg_q.data, cfg_q.fmt);
            end
          end
        end
        ST_BRK: begin
          if (!brk_req) begin
            txd_q   <= 1'b1;
            state_q <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/uart_trim_tx.sv
module uart_trim_tx
  import uart_trim_pkg::*;
#(
  parameter int DIV_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [7:0]        tx_data,
  input  logic              tx_valid,
  output logic              tx_ready,
  input  logic [DIV_W-1:0]  divisor,
  input  logic [5:0]        fmt_word,
  input  logic              brk_req,
  input  logic [TRIM_W-1:0] trim_vec,
  output logic              txd,
  output logic              tx_empty
);
  logic             frame_busy;
  logic             brk_hold;
  logic             last_bit;
  logic             sub_tick;
  logic             bit_done;
  logic [DIV_W-1:0] div_q;
  logic [SUB_W-1:0] bit_target;

  tx_frame_seq #(.DIV_W(DIV_W)) seq_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .tx_data    (tx_data),
    .tx_valid   (tx_valid),
    .divisor    (divisor),
    .fmt_word   (fmt_word),
    .brk_req    (brk_req),
    .trim_vec   (trim_vec),
    .bit_done   (bit_done),
    .tx_ready   (tx_ready),
    .frame_busy (frame_busy),
    .brk_hold   (brk_hold),
    .last_bit   (last_bit),
    .div_q      (div_q),
    .bit_target (bit_target),
    .txd        (txd)
  );

  tx_subtick_gen #(.DIV_W(DIV_W)) tick_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (frame_busy),
    .div      (div_q),
    .sub_tick (sub_tick)
  );

  tx_bit_timer timer_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (frame_busy),
    .sub_tick (sub_tick),
    .target   (bit_target),
    .bit_done (bit_done)
  );

  assign tx_empty = !frame_busy && !tx_valid;
endmodule

// File: rtl/uart_trim_tx_chk.sv
module uart_trim_tx_chk (
  input logic clk,
  input logic rst_n,
  input logic tx_valid,
  input logic tx_ready,
  input logic brk_req,
  input logic txd,
  input logic tx_empty,
  input logic frame_busy,
  input logic brk_hold,
  input logic sub_tick,
  input logic bit_done,
  input logic last_bit
);
  AST_IDLE_LINE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (!frame_busy && !brk_hold) |-> txd);                               // R1
  AST_START_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready) |=> (frame_busy && !txd));                  // R2
  AST_READY_WHEN_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready |-> (!frame_busy && !brk_hold && !brk_req));              // R2
  AST_BIT_ON_SUBTICK: assert property (@(posedge clk) disable iff (!rst_n)
    bit_done |-> sub_tick);                                            // R3
  AST_LINE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_busy && !bit_done) |=> $stable(txd));                       // R3
  AST_STOP_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    last_bit |-> txd);                                                 // R6
  AST_BREAK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    brk_hold |-> !txd);                                                // R8
  AST_BREAK_AFTER_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_done && last_bit && brk_req) |=> brk_hold);                   // R8
  AST_EMPTY_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_empty && !brk_hold) |-> txd);                                  // R9
endmodule

bind uart_trim_tx uart_trim_tx_chk chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .tx_valid   (tx_valid),
  .tx_ready   (tx_ready),
  .brk_req    (brk_req),
  .txd        (txd),
  .tx_empty   (tx_empty),
  .frame_busy (frame_busy),
  .brk_hold   (brk_hold),
  .sub_tick   (sub_tick),
  .bit_done   (bit_done),
  .last_bit   (last_bit)
);

// File: tb/uart_trim_tx_tb_top.sv
`timescale 1ns/1ps
module uart_trim_tx_tb_top;
  localparam int DIV_W = 12;
  localparam int NVEC  = 8;

  logic             clk = 1'b0;
  logic             rst_n;
  logic [7:0]       tx_data;
  logic             tx_valid;
  logic             tx_ready;
  logic [DIV_W-1:0] divisor;
  logic [5:0]       fmt_word;
  logic             brk_req;
  logic [23:0]      trim_vec;
  logic             txd;
  logic             tx_empty;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  uart_trim_tx #(.DIV_W(DIV_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .tx_data(tx_data), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .divisor(divisor), .fmt_word(fmt_word),
    .brk_req(brk_req), .trim_vec(trim_vec), .txd(txd), .tx_empty(tx_empty)
  );

  // {data, fmt {parity,stop,len}, trim, divisor}
  localparam logic [41:0] VEC [NVEC] = '{
    {8'hA5, 6'b000_0_11, 24'h000000, 4'd0},
    {8'h5A, 6'b101_0_11, 24'h000000, 4'd1},
    {8'h13, 6'b100_1_00, 24'h00006D, 4'd0},
    {8'h3C, 6'b110_0_01, 24'hFFFFFF, 4'd2},
    {8'h55, 6'b111_1_10, 24'h555555, 4'd1},
    {8'hFF, 6'b100_1_11, 24'hD75D37, 4'd0},
    {8'h80, 6'b010_0_11, 24'h000C00, 4'd0},
    {8'h0F, 6'b101_0_10, 24'hAAAAAA, 4'd1}
  };

  task automatic check(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic send_frame(input logic [7:0] d, input logic [5:0] f,
                            input logic [23:0] t, input logic [3:0] dv,
                            input int vid, input bit scramble, input bit brk_mid);
    logic lv [12];
    int   wid [12];
    int   n, nd, ones, code, bad_cyc;
    logic got;
    bit   first;
    nd = 5 + int'(f[1:0]);
    ones = 0;
    lv[0] = 1'b0;
    for (int i = 0; i < nd; i++) begin
      lv[1+i] = d[i];
      ones += int'(d[i]);
    end
    n = 1 + nd;
    if (f[5]) begin
      case (f[5:3])
        3'd4: lv[n] = (ones % 2 == 0);
        3'd5: lv[n] = (ones % 2 == 1);
        3'd6: lv[n] = 1'b1;
        default: lv[n] = 1'b0;
      endcase
      n++;
    end
    for (int s = 0; s < (f[2] ? 2 : 1); s++) begin
      lv[n] = 1'b1;
      n++;
    end
    for (int p = 0; p < n; p++) begin
      code = int'(t[2*p +: 2]);
      wid[p] = (16 + (code == 1 ? 1 : 0) - (code == 3 ? 1 : 0)) * (int'(dv) + 1);
    end

    @(negedge clk);
    tx_data = d; fmt_word = f; trim_vec = t; divisor = DIV_W'(dv); tx_valid = 1'b1;
    @(negedge clk);
    tx_valid = 1'b0;
    check(tx_ready == 1'b0, $sformatf("R2 vec %0d ready during frame", vid),
          32'(tx_ready), 32'd0);
    if (scramble) begin
      tx_data = ~d; fmt_word = ~f; trim_vec = ~t; divisor = DIV_W'(5);
    end
    if (brk_mid) brk_req = 1'b1;
    first = 1'b1;
    for (int p = 0; p < n; p++) begin
      bad_cyc = -1;
      got = lv[p];
      for (int c = 0; c < wid[p]; c++) begin
        if (!first) @(negedge clk);
        first = 1'b0;
        if (txd !== lv[p] && bad_cyc < 0) begin
          bad_cyc = c;
          got = txd;
        end
      end
      check(bad_cyc < 0,
            $sformatf("R3/R4/R5/R6/R7%s vec %0d pos %0d cycle %0d level",
                      scramble ? "/R10" : "", vid, p, bad_cyc),
            32'(got), 32'(lv[p]));
    end
    @(negedge clk);
    if (brk_mid)
      check(txd == 1'b0 && tx_ready == 1'b0,
            $sformatf("R8 vec %0d break after frame {txd,ready}", vid),
            {30'd0, txd, tx_ready}, 32'd0);
    else
      check(txd == 1'b1 && tx_empty == 1'b1 && tx_ready == 1'b1,
            $sformatf("R9 vec %0d idle after frame {txd,empty,ready}", vid),
            {29'd0, txd, tx_empty, tx_ready}, 32'd7);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual 0 expected 1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int low_bad;
    rst_n = 1'b0; tx_data = '0; tx_valid = 1'b0; divisor = '0;
    fmt_word = '0; brk_req = 1'b0; trim_vec = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(txd == 1'b1 && tx_empty == 1'b1 && tx_ready == 1'b1,
          "R1 reset {txd,empty,ready}", {29'd0, txd, tx_empty, tx_ready}, 32'd7);

    for (int v = 0; v < NVEC; v++)
      send_frame(VEC[v][41:34], VEC[v][33:28], VEC[v][27:4], VEC[v][3:0], v, 1'b0, 1'b0);

    // R10: settings change mid-frame
    send_frame(8'h96, 6'b100_0_11, 24'h00D700, 4'd1, 100, 1'b1, 1'b0);

    // R8: break requested mid-frame, line stays low afterwards
    send_frame(8'h3A, 6'b101_1_11, 24'h000000, 4'd0, 101, 1'b0, 1'b1);
    low_bad = 0;
    repeat (15) begin
      @(negedge clk);
      if (txd !== 1'b0 || tx_ready !== 1'b0) low_bad++;
    end
    check(low_bad == 0, "R8 break held low", 32'(low_bad), 32'd0);
    brk_req = 1'b0;
    @(negedge clk);
    check(txd == 1'b1 && tx_ready == 1'b1, "R8 break release {txd,ready}",
          {30'd0, txd, tx_ready}, 32'd3);

    // R8/R9: break from idle with a byte offered
    brk_req = 1'b1; tx_valid = 1'b1; tx_data = 8'h00;
    @(negedge clk);
    check(txd == 1'b0 && tx_ready == 1'b0, "R8 idle break {txd,ready}",
          {30'd0, txd, tx_ready}, 32'd0);
    check(tx_empty == 1'b0, "R9 empty with byte offered", 32'(tx_empty), 32'd0);
    low_bad = 0;
    repeat (10) begin
      @(negedge clk);
      if (txd !== 1'b0) low_bad++;
    end
    check(low_bad == 0, "R8 byte not taken during break", 32'(low_bad), 32'd0);
    brk_req = 1'b0;
    @(negedge clk);
    check(txd == 1'b1 && tx_ready == 1'b1 && tx_empty == 1'b0,
          "R9 after break {txd,ready,empty}", {29'd0, txd, tx_ready, tx_empty}, 32'd6);
    tx_valid = 1'b0;
    @(negedge clk);
    check(tx_empty == 1'b1 && txd == 1'b1, "R9 empty after offer withdrawn {empty,txd}",
          {30'd0, tx_empty, txd}, 32'd3);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule